// File: doc/BRIEF.md
# SD Host Command and Data Inhibit Tracker

This block keeps the two "may I issue a command?" status bits of an SD/MMC host controller. The command inhibit bit covers the CMD line. It rises as soon as software writes the command transfer-type register. It drops when the matching response arrives, unless an error or an automatic stop command gets in the way. The data inhibit bit covers the DAT lines. It follows the data-line-active and read-transfer-active levels that the data path reports. It also covers the busy phase of commands that signal busy on DAT0.

Each 1-to-0 change of an inhibit bit produces a one-cycle interrupt pulse. A falling command inhibit gives command done, and a falling data inhibit gives transfer done. The transfer-done pulse is held back when the data inhibit episode was only the busy phase of a busy-signalling command. The block also gives two permission levels. The first allows CMD-line-only commands, and the second allows commands that also use the DAT lines. The card-side protocol, CRC and the data path are outside this block. All inputs and outputs are plain control and status pins, with no handshake.

Top module: `sd_inhibit_tracker`

## Requirements
- R1: Synchronous reset (`rst` high) drives both inhibit bits and both interrupt pulses to 0, so both permission outputs read 1.
- R2: A `xfer_wr_i` pulse sets `cmd_inhibit_o` to 1 on the next clock edge.
- R3: A `rsp_rcvd_i` pulse clears `cmd_inhibit_o` on the next edge when it carries no error and is not flagged auto-stop. When `cmd_inhibit_o` falls, `cmd_done_o` is 1 for exactly that one cycle.
- R4: A response that arrives while `cmd_conflict_err_i` or `autostop_miss_err_i` is 1 leaves `cmd_inhibit_o` at 1 and raises no `cmd_done_o`.
- R5: A response flagged by `rsp_autostop_i` leaves `cmd_inhibit_o` unchanged, whether it is 0 or 1, and raises no `cmd_done_o`.
- R6: When `xfer_wr_i` and a clearing response arrive in the same cycle, the set wins. `cmd_inhibit_o` is 1 afterwards and `cmd_done_o` stays 0.
- R7: `dat_inhibit_o` equals `dat_line_act_i OR rd_xfer_act_i` as sampled at the previous clock edge.
- R8: When `dat_inhibit_o` falls, `xfer_done_o` is 1 in that same cycle for one cycle, unless R9 applies.
- R9: A data inhibit episode is busy-only when two conditions hold: at its first cycle the last written command had its busy flag set (`cmd_busy_sig_i` sampled with `xfer_wr_i`), and `rd_xfer_act_i` stayed 0 for the whole episode. The end of a busy-only episode raises no `xfer_done_o`.
- R10: `cmd_only_ok_o` is the inverse of `cmd_inhibit_o` and does not depend on `dat_inhibit_o`. `dat_cmd_ok_o` is 1 only when both inhibit bits are 0.
- R11: `cmd_done_o` and `xfer_done_o` are never 1 except in a cycle where their own inhibit bit has just fallen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| xfer_wr_i | input | 1 | Pulse: command transfer-type register written |
| rsp_rcvd_i | input | 1 | Pulse: command response received |
| rsp_autostop_i | input | 1 | Qualifies `rsp_rcvd_i`: the response belongs to an automatic stop command |
| cmd_conflict_err_i | input | 1 | Command conflict error flag |
| autostop_miss_err_i | input | 1 | Flag: the automatic stop command could not be issued |
| cmd_busy_sig_i | input | 1 | Sampled with `xfer_wr_i`: the command uses busy signalling |
| dat_line_act_i | input | 1 | Level: DAT lines active |
| rd_xfer_act_i | input | 1 | Level: read transfer active |
| cmd_inhibit_o | output | 1 | Command inhibit status |
| dat_inhibit_o | output | 1 | Data inhibit status |
| cmd_done_o | output | 1 | Command complete interrupt pulse |
| xfer_done_o | output | 1 | Transfer complete interrupt pulse |
| cmd_only_ok_o | output | 1 | A CMD-line-only command may be issued |
| dat_cmd_ok_o | output | 1 | A command using the DAT lines may be issued |

## Verification
The command side is driven with clean responses, responses under each error flag, auto-stop responses at both inhibit values, and a set colliding with a clear. Together these separate a tracker that merely follows the response pulse from one that applies the blocking rules and the set-wins priority. The data side is driven three ways: with the line-active level alone, with the read level alone, and with both overlapping. It is then run through busy-only episodes, through episodes where a busy command's busy phase is joined by a read, and through plain data episodes. These show whether transfer done is suppressed exactly for busy-only episodes. Permission outputs are checked while the data side is busy and the command side is idle.

// File: rtl/sd_inh_pkg.sv
package sd_inh_pkg;

  // Kind of the current data inhibit episode.
  typedef enum logic [1:0] {
    EPI_IDLE = 2'd0,
    EPI_BUSY = 2'd1,
    EPI_XFER = 2'd2
  } dat_epi_e;

  // Bit positions of the interrupt vector used inside the top.
  localparam int unsigned IRQ_CMD  = 0;
  localparam int unsigned IRQ_XFER = 1;
  localparam int unsigned IRQ_W    = 2;

endpackage

// File: rtl/sd_inh_rsp_qual.sv
module sd_inh_rsp_qual (
  input  logic rsp_i,
  input  logic autostop_i,
  input  logic conflict_i,
  input  logic miss_i,
  output logic clr_o
);
  // A response releases the command inhibit bit only when it belongs to a
  // host-issued command and no blocking error is present.
  logic blocked;
  always_comb begin
    blocked = autostop_i | conflict_i | miss_i;
    clr_o   = rsp_i & ~blocked;
  end
endmodule

// File: rtl/sd_inh_cmd_track.sv
module sd_inh_cmd_track (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic inh_o,
  output logic done_o
);
  logic inh_q, inh_d;
  logic done_q;

  // Set has priority over clear.
  always_comb begin
    if (set_i)      inh_d = 1'b1;
    else if (clr_i) inh_d = 1'b0;
    else            inh_d = inh_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_q  <= 1'b0;
      done_q <= 1'b0;
    end else begin
      inh_q  <= inh_d;
      done_q <= inh_q & ~inh_d;
    end
  end

  assign inh_o  = inh_q;
  assign done_o = done_q;
endmodule

// File: rtl/sd_inh_dat_track.sv
module sd_inh_dat_track
  import sd_inh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xfer_wr_i,
  input  logic busy_sig_i,
  input  logic line_act_i,
  input  logic rd_act_i,
  output logic inh_o,
  output logic done_o
);
  logic     inh_q;
  logic     busy_q, busy_sel;
  logic     act_now;
  logic     done_q;
  dat_epi_e epi_q, epi_d;

  always_comb begin
    act_now  = line_act_i | rd_act_i;
    busy_sel = xfer_wr_i ? busy_sig_i : busy_q;
    epi_d    = epi_q;
    if (!act_now)     epi_d = EPI_IDLE;
    else if (rd_act_i) epi_d = EPI_XFER;
    else if (!inh_q)  epi_d = busy_sel ? EPI_BUSY : EPI_XFER;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      inh_q  <= 1'b0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
      epi_q  <= EPI_IDLE;
    end else begin
      inh_q  <= act_now;
      busy_q <= busy_sel;
      done_q <= inh_q & ~act_now & (epi_q != EPI_BUSY);
      epi_q  <= epi_d;
    end
  end

  assign inh_o  = inh_q;
  assign done_o = done_q;
endmodule

// File: rtl/sd_inhibit_tracker.sv
module sd_inhibit_tracker
  import sd_inh_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic xfer_wr_i,
  input  logic rsp_rcvd_i,
  input  logic rsp_autostop_i,
  input  logic cmd_conflict_err_i,
  input  logic autostop_miss_err_i,
  input  logic cmd_busy_sig_i,
  input  logic dat_line_act_i,
  input  logic rd_xfer_act_i,
  output logic cmd_inhibit_o,
  output logic dat_inhibit_o,
  output logic cmd_done_o,
  output logic xfer_done_o,
  output logic cmd_only_ok_o,
  output logic dat_cmd_ok_o
);
  logic              cmd_clr;
  logic              cmd_inh, dat_inh;
  logic [IRQ_W-1:0]  irq;

  sd_inh_rsp_qual u_qual (
    .rsp_i      (rsp_rcvd_i),
    .autostop_i (rsp_autostop_i),
    .conflict_i (cmd_conflict_err_i),
    .miss_i     (autostop_miss_err_i),
    .clr_o      (cmd_clr)
  );

  sd_inh_cmd_track u_cmd (
    .clk    (clk),
    .rst    (rst),
    .set_i  (xfer_wr_i),
    .clr_i  (cmd_clr),
    .inh_o  (cmd_inh),
    .done_o (irq[IRQ_CMD])
  );

  sd_inh_dat_track u_dat (
    .clk        (clk),
    .rst        (rst),
    .xfer_wr_i  (xfer_wr_i),
    .busy_sig_i (cmd_busy_sig_i),
    .line_act_i (dat_line_act_i),
    .rd_act_i   (rd_xfer_act_i),
    .inh_o      (dat_inh),
    .done_o     (irq[IRQ_XFER])
  );

  assign cmd_inhibit_o = cmd_inh;
  assign dat_inhibit_o = dat_inh;
  assign cmd_done_o    = irq[IRQ_CMD];
  assign xfer_done_o   = irq[IRQ_XFER];
  assign cmd_only_ok_o = ~cmd_inh;
  assign dat_cmd_ok_o  = ~(cmd_inh | dat_inh);
endmodule

// File: rtl/sd_inhibit_tracker_chk.sv
module sd_inhibit_tracker_chk (
  input logic clk,
  input logic rst,
  input logic xfer_wr_i,
  input logic rsp_rcvd_i,
  input logic rsp_autostop_i,
  input logic cmd_conflict_err_i,
  input logic autostop_miss_err_i,
  input logic dat_line_act_i,
  input logic rd_xfer_act_i,
  input logic cmd_inhibit_o,
  input logic dat_inhibit_o,
  input logic cmd_done_o,
  input logic xfer_done_o
);
  a_r2_set_on_write: assert property (@(posedge clk) disable iff (rst)
    xfer_wr_i |=> cmd_inhibit_o);

  a_r3_clear_on_rsp: assert property (@(posedge clk) disable iff (rst)
    (cmd_inhibit_o && rsp_rcvd_i && !rsp_autostop_i && !cmd_conflict_err_i
     && !autostop_miss_err_i && !xfer_wr_i) |=> (!cmd_inhibit_o && cmd_done_o));

  a_r4_err_holds: assert property (@(posedge clk) disable iff (rst)
    (cmd_inhibit_o && (cmd_conflict_err_i || autostop_miss_err_i))
      |=> (cmd_inhibit_o && !cmd_done_o));

  a_r5_autostop_no_effect: assert property (@(posedge clk) disable iff (rst)
    (rsp_autostop_i && !xfer_wr_i) |=> ($stable(cmd_inhibit_o) && !cmd_done_o));

  a_r6_set_wins: assert property (@(posedge clk) disable iff (rst)
    (xfer_wr_i && rsp_rcvd_i) |=> (cmd_inhibit_o && !cmd_done_o));

  a_r7_dat_follows: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> (dat_inhibit_o == $past(dat_line_act_i || rd_xfer_act_i)));

  a_r11_cc_on_fall: assert property (@(posedge clk) disable iff (rst)
    cmd_done_o |-> $fell(cmd_inhibit_o));

  a_r11_tc_on_fall: assert property (@(posedge clk) disable iff (rst)
    xfer_done_o |-> $fell(dat_inhibit_o));
endmodule

bind sd_inhibit_tracker sd_inhibit_tracker_chk u_chk (
  .clk                 (clk),
  .rst                 (rst),
  .xfer_wr_i           (xfer_wr_i),
  .rsp_rcvd_i          (rsp_rcvd_i),
  .rsp_autostop_i      (rsp_autostop_i),
  .cmd_conflict_err_i  (cmd_conflict_err_i),
  .autostop_miss_err_i (autostop_miss_err_i),
  .dat_line_act_i      (dat_line_act_i),
  .rd_xfer_act_i       (rd_xfer_act_i),
  .cmd_inhibit_o       (cmd_inhibit_o),
  .dat_inhibit_o       (dat_inhibit_o),
  .cmd_done_o          (cmd_done_o),
  .xfer_done_o         (xfer_done_o)
);

// File: tb/sim_sd_inhibit_tracker.sv
`timescale 1ns/1ps
module sim_sd_inhibit_tracker;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst, xw, rsp, au, cf, ms, bz, dl, rt;
  logic cmd_inh, dat_inh, cc, tc, c_ok, d_ok;

  sd_inhibit_tracker u0 (
    .clk(clk), .rst(rst), .xfer_wr_i(xw), .rsp_rcvd_i(rsp),
    .rsp_autostop_i(au), .cmd_conflict_err_i(cf), .autostop_miss_err_i(ms),
    .cmd_busy_sig_i(bz), .dat_line_act_i(dl), .rd_xfer_act_i(rt),
    .cmd_inhibit_o(cmd_inh), .dat_inhibit_o(dat_inh), .cmd_done_o(cc),
    .xfer_done_o(tc), .cmd_only_ok_o(c_ok), .dat_cmd_ok_o(d_ok)
  );

  // Staging values for the next cycle; pulses auto-clear after use.
  logic s_rst = 1'b1, s_xw = 0, s_rsp = 0, s_au = 0, s_cf = 0, s_ms = 0, s_bz = 0;
  logic s_dl = 0, s_rt = 0;

  // Reference state, built from the requirements.
  logic m_cmd = 0, m_dat = 0, m_busy = 0;
  int   m_epi = 0; // 0 none, 1 busy-only, 2 data

  logic [5:0] exp_q[$];
  string      tag_q[$];
  int n_run = 0, n_fail = 0;
  bit done = 0;

  initial begin
    rst = 1; xw = 0; rsp = 0; au = 0; cf = 0; ms = 0; bz = 0; dl = 0; rt = 0;
  end

  task automatic cyc(input string tag);
    logic nc, nd, ecc, etc, bsel, act;
    @(negedge clk);
    rst = s_rst; xw = s_xw; rsp = s_rsp; au = s_au; cf = s_cf; ms = s_ms;
    bz = s_bz; dl = s_dl; rt = s_rt;
    if (s_rst) begin
      m_cmd = 0; m_dat = 0; m_busy = 0; m_epi = 0;
      exp_q.push_back(6'b000011);
    end else begin
      nc = m_cmd;
      if (s_xw) nc = 1;                                        // R2, R6
      else if (s_rsp && !s_au && !s_cf && !s_ms) nc = 0;        // R3, R4, R5
      ecc  = m_cmd & ~nc;
      act  = s_dl | s_rt;                                       // R7
      bsel = s_xw ? s_bz : m_busy;
      etc  = m_dat & ~act & (m_epi != 1);                       // R8, R9
      if (!act) m_epi = 0;
      else if (s_rt) m_epi = 2;
      else if (!m_dat) m_epi = bsel ? 1 : 2;
      nd = act;
      m_cmd = nc; m_dat = nd; m_busy = bsel;
      exp_q.push_back({nc, nd, ecc, etc, ~nc, ~(nc | nd)});     // R10
    end
    tag_q.push_back(tag);
    s_xw = 0; s_rsp = 0; s_au = 0; s_cf = 0; s_ms = 0; s_bz = 0;
  endtask

  // Monitor: compare after each active edge.
  always @(posedge clk) begin
    #3;
    if (exp_q.size() > 0) begin
      logic [5:0] e, a;
      string t;
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      a = {cmd_inh, dat_inh, cc, tc, c_ok, d_ok};
      n_run++;
      if (a !== e) begin
        n_fail++;
        $display("FAIL %s: {cmd,dat,cc,tc,cok,dok} actual %b expected %b", t, a, e);
      end
    end
  end

  task automatic idle(input string tag, input int n);
    for (int i = 0; i < n; i++) cyc(tag);
  endtask

  initial begin
    idle("R1 reset", 3);
    s_rst = 0;
    idle("R1 after reset", 2);
    // Command side
    s_xw = 1; cyc("R2 set");
    idle("R2 hold", 2);
    s_rsp = 1; cyc("R3 clear with cc");
    cyc("R11 cc single cycle");
    s_xw = 1; cyc("R2 set again");
    s_rsp = 1; s_cf = 1; cyc("R4 conflict holds");
    s_rsp = 1; s_ms = 1; cyc("R4 autostop miss holds");
    s_rsp = 1; cyc("R3 clean clear");
    cyc("R11 idle");
    s_xw = 1; cyc("R2 set");
    s_rsp = 1; s_au = 1; cyc("R5 autostop rsp while set");
    s_rsp = 1; cyc("R3 clear after autostop");
    s_rsp = 1; s_au = 1; cyc("R5 autostop rsp while clear");
    s_xw = 1; cyc("R2 set");
    s_xw = 1; s_rsp = 1; cyc("R6 set wins");
    s_rsp = 1; cyc("R3 clear after collision");
    // Data side, plain data episodes
    s_dl = 1; idle("R7 line active", 3);
    s_xw = 1; cyc("R10 cmd-only ok while data busy");
    s_rsp = 1; cyc("R10 cmd clears, data busy");
    s_dl = 0; cyc("R8 tc on line release");
    cyc("R8 tc single cycle");
    s_rt = 1; idle("R7 read active", 2);
    s_dl = 1; cyc("R7 both active");
    s_rt = 0; cyc("R7 line only");
    s_dl = 0; cyc("R8 tc after overlap");
    // Busy-only episode
    s_xw = 1; s_bz = 1; cyc("R9 busy cmd write");
    s_rsp = 1; cyc("R9 rsp");
    s_dl = 1; idle("R9 busy phase", 3);
    s_dl = 0; cyc("R9 no tc for busy only");
    cyc("R9 idle");
    // Busy command with read joining
    s_dl = 1; cyc("R9 busy flag still latched");
    s_rt = 1; cyc("R9 read joins");
    s_rt = 0; cyc("R9 read leaves");
    s_dl = 0; cyc("R9 tc since read seen");
    // Non-busy command resets busy flag
    s_xw = 1; s_bz = 0; cyc("R9 non-busy write");
    s_rsp = 1; cyc("R3 clear");
    s_dl = 1; idle("R8 line episode", 2);
    s_dl = 0; cyc("R8 tc for data episode");
    // Reset mid-activity
    s_xw = 1; s_dl = 1; cyc("R1 activity");
    s_rst = 1; s_dl = 0; cyc("R1 reset clears");
    s_rst = 0; idle("R1 after reset", 2);
    @(negedge clk); @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      n_run++; n_fail++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule